// File: doc/BRIEF.md
# Reset and Operating Mode Controller

This controller decides which operating mode a low-power wireless node runs in after any reset, and keeps choosing between full activity and a low-current wait state once it is running. It is clocked from the always-on slow clock. After a power-on reset, or after a qualified low pulse on the synchronized external reset pin, it first asks for the configuration words to be loaded. That load is a request/done handshake with a timeout. If the done pulse never comes, the block goes on with default settings.

Once the load has finished, the controller samples the reset pin and the program-enable pin. With both low it enters in-circuit serial flash emulation. With only reset low it waits in a minimum-power hold. With reset high it boots. After the boot-complete pulse it is operational. It falls to doze when the rest of the system reports idle, and it wakes on an activity event. A low level on the external sleep pin forces doze and blocks wake-ups until the pin is released.

The outputs are a one-hot state vector and the enables for the fast oscillator and the peripheral groups, so the power manager can gate those domains directly.

Top module: `rmc_top`

## Requirements
- R1: While the power-on reset `rst_n` is low, the block is in configuration-load state (`state_oh` bit 0). In that state `cfg_req` is 1 and `cfg_dflt` is 0.
- R2: The reset pin sampled low on MIN_LOW_CYC consecutive clock edges sends the block to configuration-load on the edge of the last such sample. This happens from every state.
- R3: A low pulse on the reset pin that spans fewer than MIN_LOW_CYC sampling edges has no effect on the state.
- R4: When configuration-load completes with the reset pin low and the program-enable pin low, the block enters flash emulation (`state_oh` bit 2). It stays there whatever the program-enable pin does, until the reset pin is high, and then goes to boot.
- R5: When configuration-load completes with the reset pin low and the program-enable pin high, the block enters hold (`state_oh` bit 1). In hold both `osc_en` and `periph_en` are 0. It leaves for boot once the reset pin is high.
- R6: When configuration-load completes with the reset pin high, the block enters boot (`state_oh` bit 3). A `boot_done` pulse moves it to active (`state_oh` bit 4).
- R7: If no `cfg_done` arrives, configuration-load completes on its CFG_TIMEOUT_CYC-th edge and `cfg_dflt` becomes 1. Completion by `cfg_done` sets `cfg_dflt` to 0. `cfg_dflt` keeps its value until the next completion.
- R8: In active with `sleep_n` high, `sys_idle` moves the block to doze (`state_oh` bit 5). In doze with `sleep_n` high, `wake_evt` returns it to active. Without `wake_evt` it stays in doze.
- R9: `sleep_n` low moves active to doze. While `sleep_n` stays low, doze ignores `wake_evt`.
- R10: Exactly one `state_oh` bit is set at all times. `osc_en` is 1 in configuration-load, flash emulation, boot and active. `periph_en` is 1 only in boot and active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| pin_rst_n | input | 1 | Synchronized external reset pin, active low |
| prog_en_n | input | 1 | Program-enable pin, active low |
| sleep_n | input | 1 | Forced-doze request pin, active low |
| wake_evt | input | 1 | I/O activity seen while dozing |
| sys_idle | input | 1 | CPU and all peripherals except the slow timer are idle |
| boot_done | input | 1 | Boot sequence finished (pulse) |
| cfg_done | input | 1 | Configuration load finished (pulse) |
| cfg_req | output | 1 | Configuration load requested |
| cfg_dflt | output | 1 | Last load timed out; default settings in use |
| state_oh | output | 6 | One-hot state: 0 cfg-load, 1 hold, 2 flash-emulation, 3 boot, 4 active, 5 doze |
| osc_en | output | 1 | Fast oscillator enable |
| periph_en | output | 1 | Peripheral group enable |

## Verification
The checker watches these properties on every cycle:
- `state_oh` stays one-hot.
- A long enough low on the reset pin always lands the block in configuration-load on the next edge. The checker counts the low samples itself to know when this is due.
- Doze under a held sleep pin and flash emulation under a held reset pin do not move.
- Hold keeps both enables off.
- Completion by `cfg_done` clears the default flag.

Some behaviour only shows over a run, so the scenarios in the bench cover it:
- Where the decision after the load leads for each pin combination.
- The exact edge on which the timeout fires.
- That a pulse one sample short leaves the state alone.
- That the program-enable pin is ignored once in flash emulation.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
  localparam int NUM_STATES = 6;

  typedef enum logic [2:0] {
    ST_CFG  = 3'd0,
    ST_HOLD = 3'd1,
    ST_PROG = 3'd2,
    ST_BOOT = 3'd3,
    ST_RUN  = 3'd4,
    ST_DOZE = 3'd5
  } rmc_state_e;
endpackage

// File: rtl/rmc_pin_filter.sv
module rmc_pin_filter #(
  parameter int MIN_LOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fire
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIM    = CW'(MIN_LOW);
  localparam logic [CW-1:0] LIM_M1 = CW'(MIN_LOW - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  // Count consecutive low samples, saturating so a held level fires once.
  always_comb begin
    if (pin_n)              cnt_d = '0;
    else if (cnt_q != LIM)  cnt_d = cnt_q + 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fire = !pin_n && (cnt_q == LIM_M1);
endmodule

// File: rtl/rmc_cfg_timer.sv
module rmc_cfg_timer #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_cfg,
  input  logic restart,
  input  logic cfg_done,
  output logic cfg_go,
  output logic dflt
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIM_M1 = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          dflt_q, dflt_d;
  logic          tmo;

  assign tmo    = in_cfg && (cnt_q == LIM_M1);
  assign cfg_go = in_cfg && !restart && (cfg_done || tmo);

  always_comb begin
    if (!in_cfg || restart)   cnt_d = '0;
    else if (cnt_q != LIM_M1) cnt_d = cnt_q + 1'b1;
    else                      cnt_d = cnt_q;
    dflt_d = cfg_go ? !cfg_done : dflt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dflt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dflt_q <= dflt_d;
    end
  end

  assign dflt = dflt_q;
endmodule

// File: rtl/rmc_fsm.sv
module rmc_fsm
  import rmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       cfg_go,
  input  logic       pin_rst_n,
  input  logic       prog_en_n,
  input  logic       sleep_n,
  input  logic       wake_evt,
  input  logic       sys_idle,
  input  logic       boot_done,
  output rmc_state_e state
);
  rmc_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (fire) begin
      st_d = ST_CFG;
    end else begin
      unique case (st_q)
        ST_CFG:  if (cfg_go) begin
                   if (pin_rst_n)      st_d = ST_BOOT;
                   else if (prog_en_n) st_d = ST_HOLD;
                   else                st_d = ST_PROG;
                 end
        ST_HOLD,
        ST_PROG: if (pin_rst_n) st_d = ST_BOOT;
        ST_BOOT: if (boot_done) st_d = ST_RUN;
        ST_RUN:  if (!sleep_n || sys_idle) st_d = ST_DOZE;
        ST_DOZE: if (sleep_n && wake_evt)  st_d = ST_RUN;
        default: st_d = ST_CFG;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_CFG;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/rmc_top.sv
module rmc_top
  import rmc_pkg::*;
#(
  parameter int MIN_LOW_CYC     = 4,
  parameter int CFG_TIMEOUT_CYC = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pin_rst_n,
  input  logic                  prog_en_n,
  input  logic                  sleep_n,
  input  logic                  wake_evt,
  input  logic                  sys_idle,
  input  logic                  boot_done,
  input  logic                  cfg_done,
  output logic                  cfg_req,
  output logic                  cfg_dflt,
  output logic [NUM_STATES-1:0] state_oh,
  output logic                  osc_en,
  output logic                  periph_en
);
  logic       fire, cfg_go, in_cfg;
  rmc_state_e state;

  rmc_pin_filter #(.MIN_LOW(MIN_LOW_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_rst_n), .fire(fire)
  );

  assign in_cfg = (state == ST_CFG);

  rmc_cfg_timer #(.TIMEOUT(CFG_TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .in_cfg(in_cfg), .restart(fire),
    .cfg_done(cfg_done), .cfg_go(cfg_go), .dflt(cfg_dflt)
  );

  rmc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fire(fire), .cfg_go(cfg_go),
    .pin_rst_n(pin_rst_n), .prog_en_n(prog_en_n), .sleep_n(sleep_n),
    .wake_evt(wake_evt), .sys_idle(sys_idle), .boot_done(boot_done),
    .state(state)
  );

  for (genvar i = 0; i < NUM_STATES; i++) begin : g_oh
    assign state_oh[i] = (state == rmc_state_e'(i));
  end

  assign cfg_req   = in_cfg;
  assign osc_en    = state_oh[ST_CFG] | state_oh[ST_PROG] | state_oh[ST_BOOT] | state_oh[ST_RUN];
  assign periph_en = state_oh[ST_BOOT] | state_oh[ST_RUN];
endmodule

// File: rtl/rmc_chk.sv
module rmc_chk #(
  parameter int MIN_LOW_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_rst_n,
  input logic       sleep_n,
  input logic       cfg_done,
  input logic [5:0] state_oh,
  input logic       osc_en,
  input logic       periph_en,
  input logic       cfg_dflt
);
  int low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      low_cnt <= 0;
    else if (pin_rst_n)              low_cnt <= 0;
    else if (low_cnt < MIN_LOW_CYC)  low_cnt <= low_cnt + 1;
  end

  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_oh) == 1);

  assert_pin_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_rst_n && low_cnt == MIN_LOW_CYC - 1) |=> state_oh[0]);

  assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_oh[5] && !sleep_n && pin_rst_n) |=> state_oh[5]);

  assert_prog_stay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_oh[2] && !pin_rst_n) |=> state_oh[2]);

  assert_hold_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state_oh[1] |-> (!osc_en && !periph_en));

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_oh[0] && cfg_done && pin_rst_n) |=> !cfg_dflt);
endmodule

bind rmc_top rmc_chk #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .sleep_n(sleep_n),
  .cfg_done(cfg_done), .state_oh(state_oh), .osc_en(osc_en),
  .periph_en(periph_en), .cfg_dflt(cfg_dflt)
);

// File: tb/sim_rmc_top.sv
module sim_rmc_top;
  localparam int PERIOD = 10;
  localparam int G = 4;
  localparam int T = 8;
  localparam int S_CFG = 0, S_HOLD = 1, S_PROG = 2, S_BOOT = 3, S_RUN = 4, S_DOZE = 5;

  logic clk = 0;
  logic rst_n, pin_rst_n, prog_en_n, sleep_n, wake_evt, sys_idle, boot_done, cfg_done;
  logic cfg_req, cfg_dflt, osc_en, periph_en;
  logic [5:0] state_oh;

  int errors = 0, checks = 0;
  string cur_req = "R1";
  bit finished = 0;

  int m_st, m_rc, m_tc;
  bit m_dflt;

  always #(PERIOD/2) clk = ~clk;

  rmc_top #(.MIN_LOW_CYC(G), .CFG_TIMEOUT_CYC(T)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .prog_en_n(prog_en_n),
    .sleep_n(sleep_n), .wake_evt(wake_evt), .sys_idle(sys_idle),
    .boot_done(boot_done), .cfg_done(cfg_done), .cfg_req(cfg_req),
    .cfg_dflt(cfg_dflt), .state_oh(state_oh), .osc_en(osc_en), .periph_en(periph_en)
  );

  // Behavioural reference: what each requirement says should happen next edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = S_CFG; m_rc = 0; m_tc = 0; m_dflt = 0;
    end else begin
      bit qual, finish_cfg;
      int nxt;
      qual = !pin_rst_n && (m_rc == G - 1);
      finish_cfg = (m_st == S_CFG) && !qual && (cfg_done || m_tc == T - 1);
      nxt = m_st;
      if (qual) nxt = S_CFG;
      else if (m_st == S_CFG && finish_cfg)
        nxt = pin_rst_n ? S_BOOT : (prog_en_n ? S_HOLD : S_PROG);
      else if ((m_st == S_HOLD || m_st == S_PROG) && pin_rst_n) nxt = S_BOOT;
      else if (m_st == S_BOOT && boot_done) nxt = S_RUN;
      else if (m_st == S_RUN && (!sleep_n || sys_idle)) nxt = S_DOZE;
      else if (m_st == S_DOZE && sleep_n && wake_evt) nxt = S_RUN;
      if (finish_cfg) m_dflt = !cfg_done;
      m_tc = (m_st != S_CFG || qual) ? 0 : m_tc + 1;
      m_rc = pin_rst_n ? 0 : (m_rc < G ? m_rc + 1 : m_rc);
      m_st = nxt;
    end
  end

  function automatic logic [9:0] model_vec();
    logic [5:0] oh;
    oh = 6'b1 << m_st;
    return {m_dflt, (m_st == S_CFG),
            (m_st == S_BOOT || m_st == S_RUN),
            (m_st == S_CFG || m_st == S_PROG || m_st == S_BOOT || m_st == S_RUN), oh};
  endfunction

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(cur_req, {cfg_dflt, cfg_req, periph_en, osc_en, state_oh}, model_vec());
    end
  endtask

  task automatic expect_state(string req, int s);
    check(req, {4'b0, state_oh}, {4'b0, 6'b1 << s});
  endtask

  initial begin
    rst_n = 0; pin_rst_n = 1; prog_en_n = 1; sleep_n = 1;
    wake_evt = 0; sys_idle = 0; boot_done = 0; cfg_done = 0;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1", {cfg_dflt, cfg_req, osc_en, state_oh}, {1'b0, 1'b1, 1'b1, 6'b000001});
    rst_n = 1;
    cur_req = "R6"; tick(2);
    cfg_done = 1; tick(); cfg_done = 0;
    expect_state("R6", S_BOOT);
    check("R7", {9'b0, cfg_dflt}, 10'b0);
    tick(2); expect_state("R6", S_BOOT);
    boot_done = 1; tick(); boot_done = 0;
    expect_state("R6", S_RUN);
    check("R10", {8'b0, osc_en, periph_en}, {8'b0, 2'b11});
    // R8 idle / wake
    cur_req = "R8";
    sys_idle = 1; tick(); sys_idle = 0;
    expect_state("R8", S_DOZE);
    tick(2); expect_state("R8", S_DOZE);
    wake_evt = 1; tick(); wake_evt = 0;
    expect_state("R8", S_RUN);
    // R9 forced doze
    cur_req = "R9";
    sleep_n = 0; tick(); expect_state("R9", S_DOZE);
    wake_evt = 1; tick(3); expect_state("R9", S_DOZE);
    wake_evt = 0; sleep_n = 1; tick(); expect_state("R8", S_DOZE);
    wake_evt = 1; tick(); wake_evt = 0; expect_state("R8", S_RUN);
    // R3 glitch
    cur_req = "R3";
    pin_rst_n = 0; tick(G - 1); pin_rst_n = 1; tick();
    expect_state("R3", S_RUN);
    // R2 qualified reset then R4 flash emulation
    cur_req = "R2";
    pin_rst_n = 0; prog_en_n = 0; tick(G - 1);
    expect_state("R2", S_RUN);
    tick(); expect_state("R2", S_CFG);
    cur_req = "R4";
    cfg_done = 1; tick(); cfg_done = 0;
    expect_state("R4", S_PROG);
    prog_en_n = 1; tick(3); expect_state("R4", S_PROG);
    check("R10", {8'b0, osc_en, periph_en}, {8'b0, 2'b10});
    pin_rst_n = 1; tick(); expect_state("R4", S_BOOT);
    // R5 hold via R7 timeout
    cur_req = "R7";
    pin_rst_n = 0; tick(G); expect_state("R2", S_CFG);
    tick(T - 1); expect_state("R7", S_CFG);
    tick(); expect_state("R5", S_HOLD);
    check("R7", {9'b0, cfg_dflt}, 10'd1);
    cur_req = "R5";
    tick(3); expect_state("R5", S_HOLD);
    check("R5", {8'b0, osc_en, periph_en}, 10'b0);
    pin_rst_n = 1; tick(); expect_state("R5", S_BOOT);
    check("R7", {9'b0, cfg_dflt}, 10'd1);
    tick(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule